// File: doc/BRIEF.md
# Interrupt Source PQ State Controller

This block keeps a two-bit PQ state for each source in a small array of interrupt sources. Software and devices reach it through a memory-mapped window on a simple load/store bus. Each source owns two adjacent 64 KiB pages. The lower page is the trigger page and the upper page is the end-of-interrupt (EOI) page. For state queries and forced updates, the low address offset of a load selects the operation, not the data. A store to the trigger page is a trigger. A store at the EOI offset of the upper page completes an interrupt. Stores carry no payload, so the bus has no write-data pin.

The state codes are 00 reset (idle), 01 off, 10 pending and 11 queued. When a trigger or EOI produces a delivery event, the block posts a notification carrying the source index on a valid/ready output. The notification output follows the usual stream rules. Once `notify_valid` is high, it and `notify_src` stay unchanged until a cycle in which `notify_ready` is also high. Events raised while the output is stalled are remembered, one flag per source. Events for the same source that are still waiting merge into one. Waiting flags are issued lowest index first.

Bus requests are single-cycle strobes. A load's result appears on `bus_rdata` one cycle after the strobe and holds until the next load.

Top module: `pq_src_ctrl`

## Requirements
- R1: During and after reset every source is in state 01 (off) and `notify_valid` is low.
- R2: A load at offset 0x800 of either page of a source returns its state in `bus_rdata[1:0]` (upper bits zero) on the cycle after the strobe, and leaves the state unchanged.
- R3: A load at offset 0xC00, 0xD00, 0xE00 or 0xF00 of either page sets the state to 00, 01, 10 or 11 respectively. Offset bits 9:8 give the new value. The load returns the state as it was before the update.
- R4: A store anywhere in the trigger page (address bit 16 = 0) while the state is 00 moves the state to 10 and posts a notification carrying that source's index.
- R5: A trigger in state 10 moves the state to 11 and a trigger in state 11 keeps 11. Neither posts a notification.
- R6: A trigger in state 01 is ignored: the state stays 01 and no notification is posted.
- R7: A store at offset 0x400 of the EOI page (address bit 16 = 1) moves state 10 to 00 with no notification. It moves state 11 to 10 and posts a new notification for that source.
- R8: An EOI in state 00 or 01 leaves the state unchanged. Stores to other offsets of the EOI page have no effect.
- R9: While `notify_valid` is high and `notify_ready` is low, `notify_valid` and `notify_src` stay stable.
- R10: Notifications that wait behind a stalled output are all delivered, lowest source index first, and `notify_src` is always a valid index.
- R11: The source index is taken from address bits 17 and up. An access changes only the addressed source.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_sel | input | 1 | One-cycle access strobe |
| bus_we | input | 1 | 1 = store, 0 = load |
| bus_addr | input | ADDR_W | Window address: offset [15:0], page [16], source index [17+] |
| bus_rdata | output | DATA_W | Load result, state in bits 1:0, valid the cycle after the strobe |
| notify_valid | output | 1 | Notification available |
| notify_ready | input | 1 | Consumer accepts the notification |
| notify_src | output | IDX_W | Source index of the notification |

## Verification
Several properties are checked on every cycle. The notification output stays stable while it is stalled, and its index is always in range. A query load never disturbs the addressed state. Every load returns the state it found. A trigger in the off state changes nothing, and an EOI in the pending state clears the source. The directed scenarios show the behaviour that needs a history: a first trigger posts exactly one notification and further triggers post none; an EOI from queued re-posts; and several stalled events drain in ascending index order without loss once ready returns.

// File: rtl/pq_src_pkg.sv
package pq_src_pkg;

  typedef enum logic [1:0] {
    PQ_RESET  = 2'b00,
    PQ_OFF    = 2'b01,
    PQ_PEND   = 2'b10,
    PQ_QUEUED = 2'b11
  } pq_e;

  typedef enum logic [2:0] {
    OP_NONE,
    OP_GET,
    OP_SET,
    OP_TRIG,
    OP_EOI
  } op_e;

  localparam int unsigned PAGE_BIT = 16;
  localparam int unsigned SRC_LSB  = 17;
  localparam logic [15:0] OFS_GET  = 16'h0800;
  localparam logic [15:0] OFS_EOI  = 16'h0400;

  typedef struct packed {
    logic notify;
    pq_e  nxt;
  } step_t;

  // One state transition for one access on one source.
  function automatic step_t pq_step(op_e op, pq_e cur, pq_e setv);
    step_t s;
    s.notify = 1'b0;
    s.nxt    = cur;
    case (op)
      OP_SET: s.nxt = setv;
      OP_TRIG: begin
        case (cur)
          PQ_RESET: begin s.nxt = PQ_PEND; s.notify = 1'b1; end
          PQ_PEND:  s.nxt = PQ_QUEUED;
          default:  ;
        endcase
      end
      OP_EOI: begin
        case (cur)
          PQ_PEND:   s.nxt = PQ_RESET;
          PQ_QUEUED: begin s.nxt = PQ_PEND; s.notify = 1'b1; end
          default:   ;
        endcase
      end
      default: ;
    endcase
    return s;
  endfunction

endpackage

// File: rtl/pq_src_decode.sv
module pq_src_decode
  import pq_src_pkg::*;
#(
  parameter int NUM_SRC = 8,
  parameter int IDX_W   = 3,
  parameter int ADDR_W  = 20
) (
  input  logic              sel,
  input  logic              we,
  input  logic [ADDR_W-1:0] addr,
  output op_e               op,
  output logic [IDX_W-1:0]  idx,
  output pq_e               set_val
);

  logic [15:0] off;
  logic        page;
  logic        in_rng;
  logic        set_hit;

  assign off     = addr[15:0];
  assign page    = addr[PAGE_BIT];
  assign idx     = addr[SRC_LSB +: IDX_W];
  assign in_rng  = (int'(idx) < NUM_SRC);
  assign set_hit = (off[15:10] == 6'b000011) && (off[7:0] == 8'h00);
  assign set_val = pq_e'(off[9:8]);

  always_comb begin
    op = OP_NONE;
    if (sel && in_rng) begin
      if (!we) begin
        op = set_hit ? OP_SET : OP_GET;
      end else if (!page) begin
        op = OP_TRIG;
      end else if (off == OFS_EOI) begin
        op = OP_EOI;
      end
    end
  end

endmodule

// File: rtl/pq_src_state.sv
module pq_src_state
  import pq_src_pkg::*;
#(
  parameter int NUM_SRC = 8,
  parameter int IDX_W   = 3
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  op_e                      op,
  input  logic [IDX_W-1:0]         idx,
  input  pq_e                      set_val,
  output logic [NUM_SRC-1:0][1:0]  pq_q,
  output pq_e                      cur,
  output logic                     ev_valid,
  output logic [IDX_W-1:0]         ev_src
);

  step_t step;

  always_comb begin
    cur = PQ_OFF;
    for (int i = 0; i < NUM_SRC; i++) begin
      if (idx == IDX_W'(i)) cur = pq_e'(pq_q[i]);
    end
  end

  assign step     = pq_step(op, cur, set_val);
  assign ev_valid = (op != OP_NONE) && step.notify;
  assign ev_src   = idx;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < NUM_SRC; i++) pq_q[i] <= PQ_OFF;
    end else if (op != OP_NONE) begin
      for (int i = 0; i < NUM_SRC; i++) begin
        if (idx == IDX_W'(i)) pq_q[i] <= step.nxt;
      end
    end
  end

endmodule

// File: rtl/pq_src_notify.sv
module pq_src_notify #(
  parameter int NUM_SRC = 8,
  parameter int IDX_W   = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             ev_valid,
  input  logic [IDX_W-1:0] ev_src,
  output logic             out_valid,
  input  logic             out_ready,
  output logic [IDX_W-1:0] out_src
);

  logic [NUM_SRC-1:0] pend_q;
  logic [NUM_SRC-1:0] pend_nxt;
  logic [IDX_W-1:0]   pick;
  logic               any;
  logic               load;

  always_comb begin
    pick = '0;
    for (int i = NUM_SRC - 1; i >= 0; i--) begin
      if (pend_q[i]) pick = IDX_W'(i);
    end
  end

  assign any  = |pend_q;
  assign load = !out_valid || out_ready;

  always_comb begin
    pend_nxt = pend_q;
    if (load && any) pend_nxt[pick] = 1'b0;
    if (ev_valid)    pend_nxt[ev_src] = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pend_q    <= '0;
      out_valid <= 1'b0;
      out_src   <= '0;
    end else begin
      pend_q <= pend_nxt;
      if (load) begin
        out_valid <= any;
        if (any) out_src <= pick;
      end
    end
  end

endmodule

// File: rtl/pq_src_ctrl.sv
module pq_src_ctrl
  import pq_src_pkg::*;
#(
  parameter int NUM_SRC = 8,
  parameter int DATA_W  = 32,
  localparam int IDX_W  = (NUM_SRC > 1) ? $clog2(NUM_SRC) : 1,
  localparam int ADDR_W = SRC_LSB + IDX_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_sel,
  input  logic              bus_we,
  input  logic [ADDR_W-1:0] bus_addr,
  output logic [DATA_W-1:0] bus_rdata,
  output logic              notify_valid,
  input  logic              notify_ready,
  output logic [IDX_W-1:0]  notify_src
);

  op_e                     op;
  logic [IDX_W-1:0]        idx;
  pq_e                     set_val;
  logic [NUM_SRC-1:0][1:0] pq_q;
  pq_e                     cur;
  logic                    ev_valid;
  logic [IDX_W-1:0]        ev_src;

  pq_src_decode #(.NUM_SRC(NUM_SRC), .IDX_W(IDX_W), .ADDR_W(ADDR_W)) u_dec (
    .sel(bus_sel), .we(bus_we), .addr(bus_addr),
    .op(op), .idx(idx), .set_val(set_val)
  );

  pq_src_state #(.NUM_SRC(NUM_SRC), .IDX_W(IDX_W)) u_state (
    .clk(clk), .rst_n(rst_n), .op(op), .idx(idx), .set_val(set_val),
    .pq_q(pq_q), .cur(cur), .ev_valid(ev_valid), .ev_src(ev_src)
  );

  pq_src_notify #(.NUM_SRC(NUM_SRC), .IDX_W(IDX_W)) u_ntf (
    .clk(clk), .rst_n(rst_n), .ev_valid(ev_valid), .ev_src(ev_src),
    .out_valid(notify_valid), .out_ready(notify_ready), .out_src(notify_src)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      bus_rdata <= '0;
    end else if (bus_sel && !bus_we) begin
      if (op == OP_GET || op == OP_SET) bus_rdata <= {{(DATA_W-2){1'b0}}, cur};
      else                              bus_rdata <= '0;
    end
  end

endmodule

// File: rtl/pq_src_checker.sv
module pq_src_checker #(
  parameter int NUM_SRC = 8,
  parameter int DATA_W  = 32,
  parameter int IDX_W   = 3,
  parameter int ADDR_W  = 20
) (
  input logic                    clk,
  input logic                    rst_n,
  input logic                    bus_sel,
  input logic                    bus_we,
  input logic [ADDR_W-1:0]       bus_addr,
  input logic [DATA_W-1:0]       bus_rdata,
  input logic                    notify_valid,
  input logic                    notify_ready,
  input logic [IDX_W-1:0]        notify_src,
  input logic [NUM_SRC-1:0][1:0] pq_q
);

  logic [IDX_W-1:0]        a_idx;
  logic [IDX_W-1:0]        idx_q;
  logic [15:0]             a_off;
  logic                    a_page;
  logic                    a_rng;
  logic [1:0]              a_cur;
  logic [NUM_SRC-1:0][1:0] all_off;

  assign a_idx  = bus_addr[17 +: IDX_W];
  assign a_off  = bus_addr[15:0];
  assign a_page = bus_addr[16];
  assign a_rng  = int'(a_idx) < NUM_SRC;

  always_comb begin
    a_cur = 2'b01;
    for (int i = 0; i < NUM_SRC; i++) begin
      if (a_idx == IDX_W'(i)) a_cur = pq_q[i];
      all_off[i] = 2'b01;
    end
  end

  always_ff @(posedge clk) idx_q <= a_idx;

  assert_reset_off_R1: assert property (@(posedge clk)
    !rst_n |=> (pq_q == all_off) && !notify_valid);

  assert_get_keeps_state_R2: assert property (@(posedge clk) disable iff (!rst_n)
    bus_sel && !bus_we && a_rng && (a_off == 16'h0800) |=> $stable(pq_q));

  assert_load_returns_old_R3: assert property (@(posedge clk) disable iff (!rst_n)
    bus_sel && !bus_we && a_rng |=> bus_rdata == {{(DATA_W-2){1'b0}}, $past(a_cur)});

  assert_trigger_off_ignored_R6: assert property (@(posedge clk) disable iff (!rst_n)
    bus_sel && bus_we && !a_page && a_rng && (a_cur == 2'b01) |=> $stable(pq_q));

  assert_eoi_clears_pending_R7: assert property (@(posedge clk) disable iff (!rst_n)
    bus_sel && bus_we && a_page && a_rng && (a_off == 16'h0400) && (a_cur == 2'b10)
    |=> pq_q[idx_q] == 2'b00);

  assert_notify_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
    notify_valid && !notify_ready |=> notify_valid && $stable(notify_src));

  assert_notify_range_R10: assert property (@(posedge clk) disable iff (!rst_n)
    notify_valid |-> int'(notify_src) < NUM_SRC);

endmodule

bind pq_src_ctrl pq_src_checker #(
  .NUM_SRC(NUM_SRC), .DATA_W(DATA_W), .IDX_W(IDX_W), .ADDR_W(ADDR_W)
) u_chk (
  .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_we(bus_we),
  .bus_addr(bus_addr), .bus_rdata(bus_rdata), .notify_valid(notify_valid),
  .notify_ready(notify_ready), .notify_src(notify_src), .pq_q(pq_q)
);

// File: tb/pq_src_ctrl_tb.sv
module pq_src_ctrl_tb;
  localparam int CLK_PERIOD = 10;
  localparam int NUM_SRC    = 8;
  localparam int DATA_W     = 32;
  localparam int IDX_W      = 3;
  localparam int ADDR_W     = 20;

  logic              clk = 1'b0;
  logic              rst_n = 1'b0;
  logic              bus_sel = 1'b0;
  logic              bus_we = 1'b0;
  logic [ADDR_W-1:0] bus_addr = '0;
  logic [DATA_W-1:0] bus_rdata;
  logic              notify_valid;
  logic              notify_ready = 1'b0;
  logic [IDX_W-1:0]  notify_src;

  int n_chk = 0;
  int n_bad = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  pq_src_ctrl #(.NUM_SRC(NUM_SRC), .DATA_W(DATA_W)) u_dut (
    .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_we(bus_we),
    .bus_addr(bus_addr), .bus_rdata(bus_rdata), .notify_valid(notify_valid),
    .notify_ready(notify_ready), .notify_src(notify_src)
  );

  function automatic logic [ADDR_W-1:0] a_of(int s, int pg, int off);
    return ADDR_W'((s << 17) | (pg << 16) | off);
  endfunction

  task automatic check(string req, string what, int act, int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s: %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  task automatic do_load(logic [ADDR_W-1:0] a, output logic [DATA_W-1:0] d);
    @(negedge clk);
    bus_sel = 1'b1; bus_we = 1'b0; bus_addr = a;
    @(negedge clk);
    bus_sel = 1'b0;
    d = bus_rdata;
  endtask

  task automatic do_store(logic [ADDR_W-1:0] a);
    @(negedge clk);
    bus_sel = 1'b1; bus_we = 1'b1; bus_addr = a;
    @(negedge clk);
    bus_sel = 1'b0; bus_we = 1'b0;
  endtask

  task automatic chk_state(int s, int exp, string req);
    logic [DATA_W-1:0] d;
    do_load(a_of(s, 1, 'h800), d);
    check(req, $sformatf("state of src %0d", s), int'(d), exp);
  endtask

  task automatic set_state(int s, int v, output int old);
    logic [DATA_W-1:0] d;
    do_load(a_of(s, 1, 'hC00 | (v << 8)), d);
    old = int'(d);
  endtask

  task automatic expect_notify(int s, string req);
    int n = 0;
    while (!notify_valid && n < 8) begin
      @(negedge clk);
      n++;
    end
    check(req, "notify valid", int'(notify_valid), 1);
    check(req, "notify src", int'(notify_src), s);
    notify_ready = 1'b1;
    @(negedge clk);
    notify_ready = 1'b0;
  endtask

  task automatic expect_none(string req);
    int seen = 0;
    repeat (4) begin
      @(negedge clk);
      if (notify_valid) seen = 1;
    end
    check(req, "unexpected notify", seen, 0);
  endtask

  task automatic t_reset();
    check("R1", "notify_valid after reset", int'(notify_valid), 0);
    for (int s = 0; s < NUM_SRC; s++) chk_state(s, 1, "R1");
  endtask

  task automatic t_get_set();
    int old;
    set_state(3, 2, old);
    check("R3", "set returns old", old, 1);
    chk_state(3, 2, "R2");
    chk_state(3, 2, "R2");
    set_state(3, 0, old);
    check("R3", "set returns old", old, 2);
    chk_state(3, 0, "R3");
    set_state(3, 3, old);
    chk_state(3, 3, "R3");
    begin
      logic [DATA_W-1:0] d;
      do_load(a_of(6, 0, 'hF00), d);
      check("R11", "trigger-page set returns old", int'(d), 1);
    end
    chk_state(6, 3, "R11");
    chk_state(5, 1, "R11");
    chk_state(7, 1, "R11");
  endtask

  task automatic t_trigger();
    int old;
    set_state(1, 0, old);
    do_store(a_of(1, 0, 'h0));
    expect_notify(1, "R4");
    chk_state(1, 2, "R4");
    do_store(a_of(1, 0, 'h10));
    expect_none("R5");
    chk_state(1, 3, "R5");
    do_store(a_of(1, 0, 'h0));
    expect_none("R5");
    chk_state(1, 3, "R5");
  endtask

  task automatic t_trig_off();
    do_store(a_of(4, 0, 'h0));
    expect_none("R6");
    chk_state(4, 1, "R6");
  endtask

  task automatic t_eoi();
    int old;
    do_store(a_of(1, 1, 'h400));
    expect_notify(1, "R7");
    chk_state(1, 2, "R7");
    do_store(a_of(1, 1, 'h000));
    chk_state(1, 2, "R8");
    do_store(a_of(1, 1, 'h400));
    expect_none("R7");
    chk_state(1, 0, "R7");
    do_store(a_of(1, 1, 'h400));
    expect_none("R8");
    chk_state(1, 0, "R8");
    set_state(1, 1, old);
    do_store(a_of(1, 1, 'h400));
    expect_none("R8");
    chk_state(1, 1, "R8");
  endtask

  task automatic t_backpressure();
    int old;
    int bad = 0;
    set_state(7, 0, old);
    set_state(5, 0, old);
    set_state(2, 0, old);
    do_store(a_of(7, 0, 'h0));
    repeat (3) @(negedge clk);
    do_store(a_of(5, 0, 'h0));
    do_store(a_of(2, 0, 'h0));
    repeat (4) begin
      @(negedge clk);
      if (!notify_valid || notify_src != 3'd7) bad = 1;
    end
    check("R9", "stalled notify stable", bad, 0);
    expect_notify(7, "R9");
    expect_notify(2, "R10");
    expect_notify(5, "R10");
    expect_none("R10");
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog: run did not finish, actual=hung expected=done");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    t_reset();
    t_get_set();
    t_trigger();
    t_trig_off();
    t_eoi();
    t_backpressure();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

endmodule